// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Unit

This block turns device events into message-signalled interrupt writes. It serves one configuration-change event and a set of queue events. Software programs it through a small word-addressed register window. The window holds a vector table in which each entry has a 64-bit target address, a 32-bit payload and a mask bit. It also holds a global enable and, when sharing is strapped on, a programmable table that maps each event to a vector. Software first picks a vector with the select register. It then loads the address and payload into staging registers and commits them with a command write. Further commands mask, unmask and route events.

When an event arrives, the unit resolves it to a vector. Without sharing the mapping is fixed: the configuration event uses vector 0 and queue q uses vector q+1. With sharing, the mapping comes from the routing table. A usable vector gets a pending bit. Unmasked pending vectors are released one at a time, lowest index first, as an address/payload message on a valid/ready port. An event that cannot be delivered raises a one-cycle drop flag and is discarded. The bus master that carries the message out, and any wired interrupt fallback, sit outside this block. The capability is meant to be advertised to software through feature bit 40 of the device's feature set.

Top module: `msi_vec_unit`

## Requirements
- R1: After reset the global enable is clear, every vector is unmasked with nothing pending, every routing entry holds 0xFFFFFFFF (no vector), `msg_valid` is low and `evt_drop` is low.
- R2: A read of offset 0x0C0 returns NUM_VEC. A read of 0x0C4 returns the global enable in bit 0, the `share_mode` strap in bit 1 and zero in bits 31:2. Any other offset reads as zero.
- R3: A write to 0x0C8 is a command whose code sits in bits 7:0. Code 1 sets the global enable and code 2 clears it. Codes outside 1..7 change nothing.
- R4: Writes to 0x0D4 (address bits 31:0), 0x0D8 (address bits 63:32) and 0x0DC (payload) only load staging registers. Command 3 copies the staged values into the vector held in the select register (0x0D0). A select value of NUM_VEC or more makes commands 3, 4 and 5 do nothing.
- R5: With `share_mode` low, the configuration event targets vector 0 and queue q targets vector q+1.
- R6: With `share_mode` high, command 6 routes the configuration event to the selected value, and command 7 routes the queue numbered by command bits 31:16 to the selected value. With `share_mode` low both commands are ignored.
- R7: An event whose target is 0xFFFFFFFF or NUM_VEC or more, or that arrives while the global enable is clear, sends no message. It raises `evt_drop` for exactly the cycle after the clock edge that sampled it.
- R8: Command 4 masks the selected vector and command 5 unmasks it. Events to a masked vector set its pending bit without sending anything. On unmask, one message is sent, however many events arrived while it was masked.
- R9: An event sampled at edge N, with the output free, gives `msg_valid` high after edge N+1, carrying that vector's committed address and payload. The message stays stable until it is taken with `msg_ready` high.
- R10: When several unmasked vectors are pending, messages leave in increasing vector order.
- R11: Pending vectors are held, not sent, while the global enable is clear, and they are sent once it is set again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_mode | input | 1 | Strap selecting programmable (1) or fixed (0) event routing |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 12 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_off | input | 12 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| evt_valid | input | 1 | Event strobe |
| evt_cfg | input | 1 | Event is the configuration event (else a queue event) |
| evt_queue | input | QW | Queue number of a queue event |
| evt_drop | output | 1 | One-cycle pulse: the last event could not be delivered |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Consumer takes the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
A wrong routing entry or a wrong fixed mapping shows up two edges after the event. Either the message carries another vector's address and payload, or a drop pulse appears where a message was due. A staging value that leaks into the table before commit changes the next message from that vector. A lost mask or pending bit shows up as a message during masking, or as no message one edge after unmask. A broken priority or holding path shows up while `msg_ready` is low, as a message that changes, or as messages that come out of order once it is released.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam logic [11:0] OFF_VCNT  = 12'h0C0;
  localparam logic [11:0] OFF_STATE = 12'h0C4;
  localparam logic [11:0] OFF_CMD   = 12'h0C8;
  localparam logic [11:0] OFF_SEL   = 12'h0D0;
  localparam logic [11:0] OFF_ALO   = 12'h0D4;
  localparam logic [11:0] OFF_AHI   = 12'h0D8;
  localparam logic [11:0] OFF_DATA  = 12'h0DC;

  localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

  typedef enum logic [7:0] {
    CMD_ON      = 8'd1,
    CMD_OFF     = 8'd2,
    CMD_COMMIT  = 8'd3,
    CMD_MASK    = 8'd4,
    CMD_UNMASK  = 8'd5,
    CMD_MAP_CFG = 8'd6,
    CMD_MAP_Q   = 8'd7
  } msi_cmd_e;

  // Fixed routing: configuration event on vector 0, queue q on q+1.
  function automatic logic [31:0] fixed_vec(input logic is_cfg, input logic [15:0] q);
    return is_cfg ? 32'd0 : (32'(q) + 32'd1);
  endfunction

  function automatic logic [31:0] state_word(input logic en, input logic share);
    return {30'd0, share, en};
  endfunction
endpackage

// File: rtl/msi_cmd_regs.sv
module msi_cmd_regs import msi_pkg::*; #(
  parameter int NUM_VEC = 4,
  parameter int NUM_Q   = 4,
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        share_mode,
  input  logic        wr_en,
  input  logic [11:0] wr_off,
  input  logic [31:0] wr_data,
  output logic        msi_en,
  output logic [31:0] sel,
  output logic [63:0] stg_addr,
  output logic [31:0] stg_data,
  output logic        do_commit,
  output logic        do_mask,
  output logic        do_unmask,
  output logic [31:0] cfg_map,
  output logic [31:0] q_map [NUM_Q]
);
  logic        cmd_wr;
  logic [7:0]  code;
  logic [15:0] qarg;
  logic        sel_ok;

  assign cmd_wr = wr_en && (wr_off == OFF_CMD);
  assign code   = wr_data[7:0];
  assign qarg   = wr_data[31:16];
  assign sel_ok = sel < 32'(NUM_VEC);

  assign do_commit = cmd_wr && (code == CMD_COMMIT) && sel_ok;
  assign do_mask   = cmd_wr && (code == CMD_MASK)   && sel_ok;
  assign do_unmask = cmd_wr && (code == CMD_UNMASK) && sel_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msi_en   <= 1'b0;
      sel      <= '0;
      stg_addr <= '0;
      stg_data <= '0;
      cfg_map  <= NO_VECTOR;
      for (int i = 0; i < NUM_Q; i++) q_map[i] <= NO_VECTOR;
    end else begin
      if (wr_en) begin
        case (wr_off)
          OFF_SEL:  sel            <= wr_data;
          OFF_ALO:  stg_addr[31:0] <= wr_data;
          OFF_AHI:  stg_addr[63:32] <= wr_data;
          OFF_DATA: stg_data       <= wr_data;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        if (code == CMD_ON)  msi_en <= 1'b1;
        if (code == CMD_OFF) msi_en <= 1'b0;
        if (code == CMD_MAP_CFG && share_mode) cfg_map <= sel;
        if (code == CMD_MAP_Q && share_mode && (32'(qarg) < 32'(NUM_Q)))
          q_map[qarg[QW-1:0]] <= sel;
      end
    end
  end

  // R6
  fixed_map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(share_mode) |-> $stable(cfg_map));
endmodule

// File: rtl/msi_route.sv
module msi_route import msi_pkg::*; #(
  parameter int NUM_VEC = 4,
  parameter int NUM_Q   = 4,
  localparam int VW = $clog2(NUM_VEC),
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic          evt_valid,
  input  logic          evt_cfg,
  input  logic [QW-1:0] evt_queue,
  input  logic          share_mode,
  input  logic          msi_en,
  input  logic [31:0]   cfg_map,
  input  logic [31:0]   q_map [NUM_Q],
  output logic          hit,
  output logic [VW-1:0] hit_vec,
  output logic          miss
);
  logic [31:0] tgt;
  logic        q_ok;
  logic        usable;

  assign q_ok = evt_cfg || (32'(evt_queue) < 32'(NUM_Q));

  always_comb begin
    if (share_mode)
      tgt = evt_cfg ? cfg_map : (q_ok ? q_map[evt_queue] : NO_VECTOR);
    else
      tgt = fixed_vec(evt_cfg, 16'(evt_queue));
  end

  assign usable  = msi_en && q_ok && (tgt < 32'(NUM_VEC));
  assign hit     = evt_valid && usable;
  assign miss    = evt_valid && !usable;
  assign hit_vec = tgt[VW-1:0];
endmodule

// File: rtl/msi_vec_table.sv
module msi_vec_table #(
  parameter int NUM_VEC = 4,
  localparam int VW = $clog2(NUM_VEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          msi_en,
  input  logic          do_commit,
  input  logic          do_mask,
  input  logic          do_unmask,
  input  logic [VW-1:0] sel_idx,
  input  logic [63:0]   stg_addr,
  input  logic [31:0]   stg_data,
  input  logic          set_pend,
  input  logic [VW-1:0] set_idx,
  input  logic          msg_ready,
  output logic          msg_valid,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  logic [63:0]        v_addr [NUM_VEC];
  logic [31:0]        v_data [NUM_VEC];
  logic [NUM_VEC-1:0] v_mask, v_pend;
  logic [NUM_VEC-1:0] eligible, launch_oh;
  logic [VW-1:0]      pick_idx;
  logic               found, slot_free, launch;

  assign eligible  = v_pend & ~v_mask & {NUM_VEC{msi_en}};
  assign slot_free = !msg_valid || msg_ready;

  // Lowest eligible vector wins the output slot.
  always_comb begin
    found     = 1'b0;
    pick_idx  = '0;
    launch_oh = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (eligible[i] && !found) begin
        found    = 1'b1;
        pick_idx = VW'(i);
      end
    end
    if (found && slot_free) launch_oh[pick_idx] = 1'b1;
  end
  assign launch = found && slot_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_mask <= '0;
      v_pend <= '0;
      for (int i = 0; i < NUM_VEC; i++) begin
        v_addr[i] <= '0;
        v_data[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_VEC; i++) begin
        if (do_commit && sel_idx == VW'(i)) begin
          v_addr[i] <= stg_addr;
          v_data[i] <= stg_data;
        end
        if (do_mask && sel_idx == VW'(i))        v_mask[i] <= 1'b1;
        else if (do_unmask && sel_idx == VW'(i)) v_mask[i] <= 1'b0;
        if (set_pend && set_idx == VW'(i))       v_pend[i] <= 1'b1;
        else if (launch_oh[i])                   v_pend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (launch) begin
      msg_valid <= 1'b1;
      msg_addr  <= v_addr[pick_idx];
      msg_data  <= v_data[pick_idx];
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R9
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  // R11
  launch_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(msi_en));

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_chk
    // R8
    masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      v_pend[g] && v_mask[g] |=> v_pend[g]);
  end
endmodule

// File: rtl/msi_vec_unit.sv
module msi_vec_unit import msi_pkg::*; #(
  parameter int NUM_VEC = 4,
  parameter int NUM_Q   = 4,
  localparam int VW = $clog2(NUM_VEC),
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          share_mode,
  input  logic          wr_en,
  input  logic [11:0]   wr_off,
  input  logic [31:0]   wr_data,
  input  logic [11:0]   rd_off,
  output logic [31:0]   rd_data,
  input  logic          evt_valid,
  input  logic          evt_cfg,
  input  logic [QW-1:0] evt_queue,
  output logic          evt_drop,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [63:0]   msg_addr,
  output logic [31:0]   msg_data
);
  initial if (NUM_VEC < 2) $error("NUM_VEC must be at least 2");

  logic        msi_en, do_commit, do_mask, do_unmask;
  logic [31:0] sel, stg_data, cfg_map;
  logic [63:0] stg_addr;
  logic [31:0] q_map [NUM_Q];
  logic        route_hit, route_miss;
  logic [VW-1:0] route_vec;

  msi_cmd_regs #(.NUM_VEC(NUM_VEC), .NUM_Q(NUM_Q)) u_regs (
    .clk(clk), .rst_n(rst_n), .share_mode(share_mode),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .msi_en(msi_en), .sel(sel), .stg_addr(stg_addr), .stg_data(stg_data),
    .do_commit(do_commit), .do_mask(do_mask), .do_unmask(do_unmask),
    .cfg_map(cfg_map), .q_map(q_map)
  );

  msi_route #(.NUM_VEC(NUM_VEC), .NUM_Q(NUM_Q)) u_route (
    .evt_valid(evt_valid), .evt_cfg(evt_cfg), .evt_queue(evt_queue),
    .share_mode(share_mode), .msi_en(msi_en),
    .cfg_map(cfg_map), .q_map(q_map),
    .hit(route_hit), .hit_vec(route_vec), .miss(route_miss)
  );

  msi_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
    .clk(clk), .rst_n(rst_n), .msi_en(msi_en),
    .do_commit(do_commit), .do_mask(do_mask), .do_unmask(do_unmask),
    .sel_idx(sel[VW-1:0]), .stg_addr(stg_addr), .stg_data(stg_data),
    .set_pend(route_hit), .set_idx(route_vec),
    .msg_ready(msg_ready), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) evt_drop <= 1'b0;
    else        evt_drop <= route_miss;
  end

  always_comb begin
    case (rd_off)
      OFF_VCNT:  rd_data = 32'(NUM_VEC);
      OFF_STATE: rd_data = state_word(msi_en, share_mode);
      default:   rd_data = 32'd0;
    endcase
  end

  // R7
  drop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_drop |-> $past(evt_valid));
endmodule

// File: tb/msi_vec_unit_tb.sv
`timescale 1ns/1ps
module msi_vec_unit_tb;
  localparam int NV = 4;
  localparam int QW = 2;
  localparam logic [11:0] A_CNT = 12'h0C0, A_ST = 12'h0C4, A_CMD = 12'h0C8,
                          A_SEL = 12'h0D0, A_LO = 12'h0D4, A_HI = 12'h0D8, A_DAT = 12'h0DC;
  // fields: [7] cfg event, [6:5] queue, [4] message expected, [1:0] vector
  localparam logic [7:0] VEC_TBL [5] = '{8'h90, 8'h11, 8'h32, 8'h53, 8'h60};

  logic clk = 0, rst_n = 0, share = 0, wr_en = 0;
  logic [11:0] wr_off = 0, rd_off = 0;
  logic [31:0] wr_data = 0;
  wire  [31:0] rd_data;
  logic evt_valid = 0, evt_cfg = 0, msg_ready = 1;
  logic [QW-1:0] evt_q = 0;
  wire  evt_drop, msg_valid;
  wire  [63:0] msg_addr;
  wire  [31:0] msg_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  msi_vec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .share_mode(share),
    .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .rd_off(rd_off), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_cfg(evt_cfg), .evt_queue(evt_q),
    .evt_drop(evt_drop), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [63:0] ea(input int i);
    return {32'h0000_00F0 + 32'(i), 32'hFEE0_1000 + 32'(i) * 32'h10};
  endfunction
  function automatic logic [31:0] ed(input int i);
    return 32'h0000_5A00 + 32'(i);
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [11:0] off, input logic [31:0] d);
    wr_en = 1; wr_off = off; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic fire(input logic cfg, input logic [QW-1:0] q);
    evt_valid = 1; evt_cfg = cfg; evt_q = q;
    tick();
    evt_valid = 0;
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input string req, input logic [11:0] off, input logic [31:0] exp);
    rd_off = off; #1;
    chk(req, "register read", 64'(rd_data), 64'(exp));
  endtask

  task automatic chk_msg(input string req, input int v);
    chk(req, "msg_valid", 64'(msg_valid), 64'd1);
    chk(req, "msg_addr", msg_addr, ea(v));
    chk(req, "msg_data", 64'(msg_data), 64'(ed(v)));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 / R2 reset state and readback
    rd("R1", A_ST, 32'd0);
    rd("R2", A_CNT, 32'(NV));
    rd("R2", A_CMD, 32'd0);
    chk("R1", "msg_valid", 64'(msg_valid), 64'd0);
    chk("R1", "evt_drop", 64'(evt_drop), 64'd0);
    // R7 disabled: event dropped
    fire(1'b1, 2'd0);
    chk("R7", "drop while disabled", 64'(evt_drop), 64'd1);
    tick();
    chk("R7", "drop is one cycle", 64'(evt_drop), 64'd0);
    chk("R7", "no msg while disabled", 64'(msg_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      wr(A_SEL, 32'(i)); wr(A_LO, ea(i)[31:0]); wr(A_HI, ea(i)[63:32]);
      wr(A_DAT, ed(i)); wr(A_CMD, 32'd3);
    end
    // R3 unknown code, then enable
    wr(A_CMD, 32'd0); wr(A_CMD, 32'd9);
    rd("R3", A_ST, 32'd0);
    wr(A_CMD, 32'd1);
    rd("R3", A_ST, 32'd1);

    // R5 fixed routing table walk (queue 3 lands out of range: R7)
    for (int k = 0; k < 5; k++) begin
      fire(VEC_TBL[k][7], VEC_TBL[k][6:5]);
      chk("R7", "drop flag", 64'(evt_drop), 64'(!VEC_TBL[k][4]));
      tick();
      chk("R5", "msg_valid", 64'(msg_valid), 64'(VEC_TBL[k][4]));
      if (VEC_TBL[k][4]) begin
        chk("R5", "msg_addr", msg_addr, ea(int'(VEC_TBL[k][1:0])));
        chk("R5", "msg_data", 64'(msg_data), 64'(ed(int'(VEC_TBL[k][1:0]))));
      end
      tick();
    end

    // R4 staging without commit, out-of-range select, then commit
    wr(A_SEL, 32'd0); wr(A_LO, 32'hDEAD_0000); wr(A_DAT, 32'h0000_1234);
    fire(1'b1, 2'd0); tick();
    chk_msg("R4", 0); tick();
    wr(A_SEL, 32'd9); wr(A_CMD, 32'd3);
    fire(1'b1, 2'd0); tick();
    chk_msg("R4", 0); tick();
    wr(A_SEL, 32'd3); wr(A_CMD, 32'd3);
    fire(1'b0, 2'd2); tick();
    chk("R4", "committed addr", msg_addr, {ea(3)[63:32], 32'hDEAD_0000});
    chk("R4", "committed data", 64'(msg_data), 64'h1234);
    tick();
    wr(A_LO, ea(3)[31:0]); wr(A_DAT, ed(3)); wr(A_CMD, 32'd3);

    // R6 map command ignored in fixed mode
    wr(A_SEL, 32'd3); wr(A_CMD, 32'd6);
    fire(1'b1, 2'd0); tick();
    chk_msg("R6", 0); tick();

    // R8 mask, coalesce, unmask
    wr(A_SEL, 32'd1); wr(A_CMD, 32'd4);
    fire(1'b0, 2'd0);
    chk("R8", "no drop when masked", 64'(evt_drop), 64'd0);
    tick();
    chk("R8", "no msg when masked", 64'(msg_valid), 64'd0);
    fire(1'b0, 2'd0); tick();
    chk("R8", "still held", 64'(msg_valid), 64'd0);
    wr(A_CMD, 32'd5); tick();
    chk_msg("R8", 1); tick();
    chk("R8", "coalesced to one msg", 64'(msg_valid), 64'd0);

    // R9 / R10 backpressure and ordering
    msg_ready = 0;
    fire(1'b1, 2'd0); tick();
    chk_msg("R9", 0);
    fire(1'b0, 2'd1); fire(1'b0, 2'd0); tick();
    chk_msg("R9", 0);
    msg_ready = 1; tick();
    chk_msg("R10", 1); tick();
    chk_msg("R10", 2); tick();
    chk("R10", "drained", 64'(msg_valid), 64'd0);

    // R11 pending held across disable
    wr(A_SEL, 32'd3); wr(A_CMD, 32'd4);
    fire(1'b0, 2'd2); tick();
    wr(A_CMD, 32'd2); wr(A_CMD, 32'd5); tick(); tick();
    chk("R11", "held while disabled", 64'(msg_valid), 64'd0);
    rd("R11", A_ST, 32'd0);
    wr(A_CMD, 32'd1); tick();
    chk_msg("R11", 3); tick();

    // R6 sharing mode
    share = 1;
    rd("R2", A_ST, 32'd3);
    fire(1'b1, 2'd0);
    chk("R1", "unmapped after reset drops", 64'(evt_drop), 64'd1);
    tick();
    wr(A_SEL, 32'd2); wr(A_CMD, 32'd6);
    fire(1'b1, 2'd0); tick();
    chk_msg("R6", 2); tick();
    wr(A_SEL, 32'd1); wr(A_CMD, 32'h0003_0007);
    fire(1'b0, 2'd3);
    chk("R6", "mapped queue no drop", 64'(evt_drop), 64'd0);
    tick();
    chk_msg("R6", 1); tick();
    wr(A_SEL, 32'hFFFF_FFFF); wr(A_CMD, 32'd6);
    fire(1'b1, 2'd0);
    chk("R7", "no-vector drop", 64'(evt_drop), 64'd1);
    tick();
    chk("R7", "no msg", 64'(msg_valid), 64'd0);
    wr(A_SEL, 32'd5); wr(A_CMD, 32'h0000_0007);
    fire(1'b0, 2'd0);
    chk("R7", "out-of-range drop", 64'(evt_drop), 64'd1);
    tick();
    chk("R7", "no msg", 64'(msg_valid), 64'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule